// File: doc/BRIEF.md
# Tile row fp32 narrowing converter

This block takes one 64-byte slice of one row from a matrix tile store and narrows each 32-bit float element of that slice to a 16-bit float. The result stays in the element's own dword. A request carries three things: a 32-bit selector, a 2-bit mode and the configured bytes-per-row of the tile. The selector's low half names the row. Its high half names which 64-byte chunk of that row to take.

The row index goes straight out to a synchronous tile store, which returns the whole row one clock later. The block then picks out the slice and runs sixteen lane converters in parallel. It registers a 512-bit result together with a valid strobe. The mode picks bfloat16 or IEEE half precision as the target, and it picks whether the narrowed value sits in the upper or the lower half of each dword. The other half of each dword is zero. Lanes that fall past the configured row width are zero as well. Both formats round to nearest, ties to even.

Top module: `tile_row_narrow`

## Requirements
- R1: In the request cycle, `rd_en` equals `req_valid` and `rd_row` carries `req_sel[15:0]`. The store answers on `rd_data` one cycle later.
- R2: `out_valid` rises exactly two clock edges after the edge that samples `req_valid`. It is low one edge after that edge. Requests on consecutive cycles give results on consecutive cycles.
- R3: The chunk number is c = `req_sel[31:16]`. Lane i (bits 32i+31:32i) takes its source from dword c*16+i of the selected row, which means the byte offset is c*64.
- R4: Lane i is all zero when c*16+i >= `cfg_colsb`/4 (integer division). It is also all zero when c*16+i lies beyond the stored row width.
- R5: The mode encodings are: 2'b00 gives bfloat16 in lane bits 31:16; 2'b01 gives bfloat16 in bits 15:0; 2'b10 gives half precision in bits 31:16; 2'b11 gives half precision in bits 15:0. The unused half of each lane is zero.
- R6: bfloat16 keeps fp32 bits 31:16 and adds one when bit 15 is set and either any of bits 14:0 or bit 16 is set. Finite values can therefore round up to infinity.
- R7: A bfloat16 NaN input keeps the sign and bits 30:16 and sets bit 6 (quiet), with no rounding.
- R8: Half precision from a normal result rounds to nearest even on fp32 bit 12. Magnitudes from 65520 upward give infinity (0x7C00 with sign).
- R9: Half precision below the normal range gives a correctly rounded subnormal. It rounds up into 0x0400 where due. A magnitude of 2^-25 or less gives signed zero, with an exact 2^-25 taking the tie toward zero.
- R10: Half precision maps infinity to infinity. It maps NaN to sign, exponent 5'h1F, bit 9 set and fp32 bits 22:14 below that. It keeps the sign of zero.
- R11: After reset `out_valid` is low. Whenever `out_valid` is low, `out_data` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 32 | Row index (15:0) and chunk number (31:16) |
| req_mode | input | 2 | Target format and placement |
| cfg_colsb | input | CFG_W | Configured bytes per tile row |
| rd_en | output | 1 | Tile store read enable |
| rd_row | output | 16 | Tile store row index |
| rd_data | input | ROW_BYTES*8 | Whole row from the store, one cycle after rd_en |
| out_valid | output | 1 | Result strobe |
| out_data | output | SLICE_BYTES*8 | Sixteen narrowed dword lanes |

## Verification
The stimulus row holds rounding ties with both even and odd kept bits. A design that truncates, or rounds half up, shows it in those lanes. The row also holds the largest finite half value and the first value above it, which catch an overflow path that wraps into the exponent instead of saturating. Small values probe the subnormal shift, the carry into the smallest normal and the exact-half-of-minimum tie. NaN, infinity and negative zero check that special values skip rounding and keep their sign. Widths that end partway through a slice, and chunks past the row, expose an off-by-one or a missing scale factor in the masking.

// File: rtl/tile_row_narrow_pkg.sv
package tile_row_narrow_pkg;
  typedef enum logic [1:0] {
    NM_BF16_HI = 2'b00,
    NM_BF16_LO = 2'b01,
    NM_HALF_HI = 2'b10,
    NM_HALF_LO = 2'b11
  } narrow_mode_e;
endpackage

// File: rtl/trn_bf16_round.sv
module trn_bf16_round (
  input  logic [31:0] x,
  output logic [15:0] y
);
  logic is_nan;
  logic bump;

  always_comb begin
    is_nan = (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
    bump   = x[15] & ((|x[14:0]) | x[16]);
    if (is_nan) y = x[31:16] | 16'h0040;
    else        y = x[31:16] + {15'd0, bump};
  end
endmodule

// File: rtl/trn_half_round.sv
module trn_half_round (
  input  logic [31:0] x,
  output logic [15:0] y
);
  logic        sgn;
  logic [7:0]  ex;
  logic [22:0] mt;
  logic [23:0] sig;
  logic [7:0]  sh;
  logic [48:0] ext;
  logic [4:0]  eh;
  logic        up;
  logic [14:0] mag;

  always_comb begin
    sgn = x[31];
    ex  = x[30:23];
    mt  = x[22:0];
    sig = {1'b1, mt};
    sh  = 8'd126 - ex;
    ext = {sig, 25'd0} >> sh;
    eh  = ex[4:0] - 5'd16;
    up  = 1'b0;
    mag = 15'd0;
    if (ex == 8'hFF) begin
      mag = (mt != 23'd0) ? {5'h1F, 1'b1, mt[22:14]} : 15'h7C00;
    end else if (ex >= 8'd143) begin
      mag = 15'h7C00;
    end else if (ex >= 8'd113) begin
      up  = mt[12] & ((|mt[11:0]) | mt[13]);
      mag = {eh, mt[22:13]} + {14'd0, up};
    end else if (ex >= 8'd102) begin
      up  = ext[24] & ((|ext[23:0]) | ext[25]);
      mag = 15'(ext[48:25]) + {14'd0, up};
    end
    y = {sgn, mag};
  end
endmodule

// File: rtl/trn_lane.sv
module trn_lane
  import tile_row_narrow_pkg::*;
(
  input  logic [31:0]  src,
  input  narrow_mode_e mode,
  input  logic         live,
  output logic [31:0]  dw
);
  logic [15:0] bf_v;
  logic [15:0] hp_v;
  logic [15:0] pick;

  trn_bf16_round i_bf (.x(src), .y(bf_v));
  trn_half_round i_hp (.x(src), .y(hp_v));

  always_comb begin
    pick = mode[1] ? hp_v : bf_v;
    if (!live)        dw = 32'd0;
    else if (mode[0]) dw = {16'd0, pick};
    else              dw = {pick, 16'd0};
  end
endmodule

// File: rtl/tile_row_narrow.sv
module tile_row_narrow
  import tile_row_narrow_pkg::*;
#(
  parameter int ROW_BYTES   = 128,
  parameter int SLICE_BYTES = 64,
  parameter int CFG_W       = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [31:0]              req_sel,
  input  logic [1:0]               req_mode,
  input  logic [CFG_W-1:0]         cfg_colsb,
  output logic                     rd_en,
  output logic [15:0]              rd_row,
  input  logic [ROW_BYTES*8-1:0]   rd_data,
  output logic                     out_valid,
  output logic [SLICE_BYTES*8-1:0] out_data
);
  localparam int ROW_DW  = ROW_BYTES / 4;
  localparam int LANES   = SLICE_BYTES / 4;
  localparam int SLICE_W = SLICE_BYTES * 8;
  localparam int DW_AW   = $clog2(ROW_DW);
  localparam int GI_W    = 16 + $clog2(LANES) + 3;

  logic               s1_valid;
  narrow_mode_e       s1_mode;
  logic [15:0]        s1_chunk;
  logic [CFG_W-1:0]   s1_colsb;
  logic [31:0]        row_dw [ROW_DW];
  logic [SLICE_W-1:0] lane_bus;

  assign rd_en  = req_valid;
  assign rd_row = req_sel[15:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_mode  <= NM_BF16_HI;
      s1_chunk <= 16'd0;
      s1_colsb <= '0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_mode  <= narrow_mode_e'(req_mode);
        s1_chunk <= req_sel[31:16];
        s1_colsb <= cfg_colsb;
      end
    end
  end

  for (genvar k = 0; k < ROW_DW; k++) begin : g_split
    assign row_dw[k] = rd_data[k*32 +: 32];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [GI_W-1:0] gidx;
    logic            in_row;
    logic            live;
    logic [31:0]     src;
    always_comb begin
      gidx   = GI_W'(s1_chunk) * GI_W'(LANES) + GI_W'(i);
      in_row = gidx < GI_W'(ROW_DW);
      live   = in_row && (({gidx, 2'b00} + (GI_W+2)'(4)) <= (GI_W+2)'(s1_colsb));
      src    = in_row ? row_dw[gidx[DW_AW-1:0]] : 32'd0;
    end
    trn_lane i_lane (
      .src  (src),
      .mode (s1_mode),
      .live (live),
      .dw   (lane_bus[i*32 +: 32])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      out_data  <= s1_valid ? lane_bus : '0;
    end
  end
endmodule

// File: rtl/tile_row_narrow_chk.sv
module tile_row_narrow_chk #(
  parameter int SLICE_BYTES = 64,
  parameter int CFG_W       = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic [15:0]              chunk,
  input logic                     mode_low,
  input logic [CFG_W-1:0]         cfg_colsb,
  input logic                     out_valid,
  input logic [SLICE_BYTES*8-1:0] out_data
);
  localparam int LANES = SLICE_BYTES / 4;

  logic [1:0] age;
  logic       lo_zero;
  logic       hi_zero;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assign warm = (age >= 2'd2);

  always_comb begin
    lo_zero = 1'b1;
    hi_zero = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (out_data[i*32 +: 16] != 16'd0)      lo_zero = 1'b0;
      if (out_data[i*32+16 +: 16] != 16'd0)   hi_zero = 1'b0;
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ##2 out_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    (out_valid && warm) |-> $past(req_valid, 2)); // R2
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0)); // R11
  AST_HIGH_PLACE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && warm && !$past(mode_low, 2)) |-> lo_zero); // R5
  AST_LOW_PLACE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && warm && $past(mode_low, 2)) |-> hi_zero); // R5
  AST_CHUNK_MASKED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && warm && ($past(chunk, 2) != 16'd0)
     && ($past(cfg_colsb, 2) <= CFG_W'(SLICE_BYTES))) |-> (out_data == '0)); // R4
endmodule

bind tile_row_narrow tile_row_narrow_chk #(
  .SLICE_BYTES(SLICE_BYTES),
  .CFG_W      (CFG_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .chunk    (req_sel[31:16]),
  .mode_low (req_mode[0]),
  .cfg_colsb(cfg_colsb),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/test_tile_row_narrow.sv
`timescale 1ns/1ps
module test_tile_row_narrow;
  localparam int ROW_BYTES = 128;
  localparam int SLICE_BYTES = 64;
  localparam int CFG_W = 16;
  localparam int NV = 20;

  localparam logic [31:0] V_IN [NV] = '{
    32'h3F800000, 32'hC0000000, 32'h3F808000, 32'h3F818000, 32'h3F800001,
    32'h3F801000, 32'h3F803000, 32'h477FE000, 32'h477FF000, 32'h47C35000,
    32'h7F800000, 32'h7F800001, 32'h80000000, 32'h33800000, 32'h33000000,
    32'h33000001, 32'h387FF000, 32'h38000000, 32'h7F7FFFFF, 32'hBFC00000};
  localparam logic [15:0] V_BF [NV] = '{
    16'h3F80, 16'hC000, 16'h3F80, 16'h3F82, 16'h3F80,
    16'h3F80, 16'h3F80, 16'h4780, 16'h4780, 16'h47C3,
    16'h7F80, 16'h7FC0, 16'h8000, 16'h3380, 16'h3300,
    16'h3300, 16'h3880, 16'h3800, 16'h7F80, 16'hBFC0};
  localparam logic [15:0] V_HP [NV] = '{
    16'h3C00, 16'hC000, 16'h3C04, 16'h3C0C, 16'h3C00,
    16'h3C00, 16'h3C02, 16'h7BFF, 16'h7C00, 16'h7C00,
    16'h7C00, 16'h7E00, 16'h8000, 16'h0001, 16'h0000,
    16'h0001, 16'h0400, 16'h0200, 16'h7C00, 16'hBE00};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_sel = '0;
  logic [1:0] req_mode = '0;
  logic [CFG_W-1:0] cfg_colsb = '0;
  logic rd_en;
  logic [15:0] rd_row;
  logic [ROW_BYTES*8-1:0] rd_data;
  logic out_valid;
  logic [SLICE_BYTES*8-1:0] out_data;
  logic [ROW_BYTES*8-1:0] mem [16];

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_row[3:0]];

  tile_row_narrow #(.ROW_BYTES(ROW_BYTES), .SLICE_BYTES(SLICE_BYTES), .CFG_W(CFG_W)) i_tile_row_narrow (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
    .req_mode(req_mode), .cfg_colsb(cfg_colsb), .rd_en(rd_en), .rd_row(rd_row),
    .rd_data(rd_data), .out_valid(out_valid), .out_data(out_data));

  function automatic logic [15:0] conv_of(int row, int g, bit hp);
    if (row == 5) return 16'hC000;
    if (g < NV) return hp ? V_HP[g] : V_BF[g];
    return hp ? 16'h3C00 : 16'h3F80;
  endfunction

  function automatic logic [SLICE_BYTES*8-1:0] exp_vec(int row, int chunk, logic [1:0] mode, int colsb);
    logic [SLICE_BYTES*8-1:0] v = '0;
    for (int i = 0; i < SLICE_BYTES/4; i++) begin
      int g = chunk * (SLICE_BYTES/4) + i;
      if (g < colsb/4 && g < ROW_BYTES/4) begin
        logic [15:0] c = conv_of(row, g, mode[1]);
        v[i*32 +: 32] = mode[0] ? {16'h0, c} : {c, 16'h0};
      end
    end
    return v;
  endfunction

  task automatic check1(bit ok, string tag, logic [SLICE_BYTES*8-1:0] got, logic [SLICE_BYTES*8-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run_req(int row, int chunk, logic [1:0] mode, int colsb, string tag);
    logic [SLICE_BYTES*8-1:0] e;
    @(negedge clk);
    req_valid = 1'b1;
    req_sel = {16'(chunk), 16'(row)};
    req_mode = mode;
    cfg_colsb = CFG_W'(colsb);
    #1;
    check1(rd_en && rd_row == 16'(row), "R1 read request", {496'd0, rd_row}, 512'(row));
    @(negedge clk);
    req_valid = 1'b0;
    check1(!out_valid, "R2 early valid", {511'd0, out_valid}, '0);
    @(negedge clk);
    e = exp_vec(row, chunk, mode, colsb);
    check1(out_valid && out_data == e, tag, out_data, e);
  endtask

  initial begin
    for (int r = 0; r < 16; r++) mem[r] = '0;
    for (int k = 0; k < ROW_BYTES/4; k++) begin
      mem[3][k*32 +: 32] = (k < NV) ? V_IN[k] : 32'h3F800000;
      mem[5][k*32 +: 32] = 32'hC0000000;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check1(!out_valid && out_data == '0, "R11 reset state", out_data, '0);

    // Table walk: every mode over both chunks of the stimulus row
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 2; c++) begin
        run_req(3, c, 2'(m), ROW_BYTES,
                m[1] ? "R3 R5 R8 R9 R10 half lanes" : "R3 R5 R6 R7 bf16 lanes");
      end
    end

    run_req(5, 0, 2'b10, ROW_BYTES, "R1 other row selected");
    run_req(3, 0, 2'b01, 40, "R4 partial width mask");
    run_req(3, 0, 2'b11, 41, "R4 width not multiple of four");
    run_req(3, 1, 2'b00, 64, "R4 chunk beyond width");
    run_req(3, 2, 2'b10, ROW_BYTES, "R4 chunk beyond stored row");

    // R2 back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_sel = {16'd0, 16'd5}; req_mode = 2'b00; cfg_colsb = CFG_W'(ROW_BYTES);
    @(negedge clk);
    req_sel = {16'd0, 16'd3}; req_mode = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    check1(out_valid && out_data == exp_vec(5, 0, 2'b00, ROW_BYTES), "R2 first of pair",
           out_data, exp_vec(5, 0, 2'b00, ROW_BYTES));
    @(negedge clk);
    check1(out_valid && out_data == exp_vec(3, 0, 2'b11, ROW_BYTES), "R2 second of pair",
           out_data, exp_vec(3, 0, 2'b11, ROW_BYTES));
    @(negedge clk);
    check1(!out_valid && out_data == '0, "R11 idle after result", out_data, '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule